// File: doc/BRIEF.md
# Flash Sector Protection Controller

This block sits in front of a 2 Mbyte program-flash array and decides, one command per cycle, whether a read, a page program, a sector erase or a protection-setting command may reach the array. The array is split from address zero upward into thirteen sectors of unequal size: eight of 16 Kbyte, one of 128 Kbyte, one of 256 Kbyte and three of 512 Kbyte. Each incoming byte address is decoded to a sector index. That index selects the sector's write-protect bit and its permanent-lock bit.

Protection comes from four sources. Per-sector write protection can be changed at run time. Per-sector locks can never be lifted. A global read protection also blocks every program and erase. A two-word password sequence lifts write protection and read protection until an explicit relock command or a reset. Every protection setting is reloaded from configuration inputs while reset is held. A command that is allowed drives a single-cycle request to the array in the cycle it is presented. A registered response, either grant or deny with an error code, follows one cycle later.

Top module: `flash_guard`

## Requirements
- R1: The sector index sent to the array is 0..7 for the 16 Kbyte sectors below 128 K, 8 for [128 K, 256 K), 9 for [256 K, 512 K), 10 for [512 K, 1 M), 11 for [1 M, 1.5 M) and 12 for [1.5 M, 2 M).
- R2: While rst_n is low, rsp_valid and pw_err read 0 and cmd_ready reads 1. The write-protect mask, the lock mask and the read-protect flag are loaded from cfg_wp, cfg_lock and cfg_rdprot, and the password unlock is cleared.
- R3: An address at or above 2 Mbyte used with a read, program, erase or protect-set command is denied with error 2, and no array request is made.
- R4: A program command (opcode 1) whose address is not 256-byte aligned is denied with error 1 and makes no request. An aligned, permitted program raises arr_req with arr_op 1 in the same cycle.
- R5: A program or erase (opcode 2) aimed at a write-protected sector is denied with error 3 while no unlock is in effect. An erase that is permitted requests only the addressed sector.
- R6: A program, erase or protect-set aimed at a locked sector is always denied with error 4, including after a correct password.
- R7: While read protection is active and no unlock is in effect, every read (opcode 0), program and erase is denied with error 5 and makes no request. A denied read returns all-zero data with rsp_viol set.
- R8: A key command (opcode 3) carrying KEY_A, followed by a key command carrying KEY_B, unlocks the array. From the next command onward, write protection on sectors that are not locked is lifted, and so is read protection.
- R9: A key word that does not match the word expected at the current stage is denied with error 6, returns the sequence to its first stage and sets pw_err. pw_err stays set until reset.
- R10: A relock command (opcode 4) is granted, ends any unlock and restarts the password sequence.
- R11: A protect-set command (opcode 5) on a sector that is not locked is granted and writes cmd_key bit 0 into that sector's write-protect bit.
- R12: Opcodes 6 and 7 are denied with error 7. A granted response carries error 0, and a granted read returns arr_rdata as it was in the command cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is loaded while it is low |
| cfg_wp | input | 13 | Initial write-protect mask, one bit per sector |
| cfg_lock | input | 13 | Permanent lock mask, one bit per sector |
| cfg_rdprot | input | 1 | Initial global read protection |
| cmd_valid | input | 1 | A command is presented |
| cmd_ready | output | 1 | Always 1: one command is accepted every cycle |
| cmd_op | input | 3 | Opcode: 0 read, 1 program, 2 erase, 3 key, 4 relock, 5 protect-set |
| cmd_addr | input | 24 | Byte address |
| cmd_key | input | 64 | Password word; bit 0 is the new protect bit for protect-set |
| rsp_valid | output | 1 | Response for the previous cycle's command |
| rsp_grant | output | 1 | Command was allowed |
| rsp_err | output | 3 | 0 ok, 1 misaligned, 2 range, 3 write-protected, 4 locked, 5 read-protected, 6 bad key, 7 bad opcode |
| rsp_rdata | output | 64 | Read data; zero unless a read was granted |
| rsp_viol | output | 1 | A read was blocked by read protection |
| pw_err | output | 1 | Sticky wrong-password flag |
| arr_req | output | 1 | Request to the array |
| arr_op | output | 3 | Opcode of the request |
| arr_sector | output | 4 | Decoded sector index |
| arr_addr | output | 24 | Byte address to the array |
| arr_rdata | input | 64 | Array read data, valid in the request cycle |

## Verification
The decision for a command can fall in the same cycle as the unlock register update caused by the command just before it. The key word that completes the password, or a relock, is followed with no idle cycle by a program to a protected sector. That program must be judged with the new unlock state. The bench drives these commands back to back. It checks that the program right after the second key word is granted and makes its request, and that the program right after a relock is refused with error 3 and makes no request. The same back-to-back pattern is used with read protection active, where the read issued straight after unlock must return array data.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_KEY    = 3'd3,
        OP_RELOCK = 3'd4,
        OP_WPSET  = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        ERR_OK       = 3'd0,
        ERR_MISALIGN = 3'd1,
        ERR_RANGE    = 3'd2,
        ERR_WPROT    = 3'd3,
        ERR_LOCKED   = 3'd4,
        ERR_RPROT    = 3'd5,
        ERR_BADKEY   = 3'd6,
        ERR_BADOP    = 3'd7
    } err_e;

endpackage

// File: rtl/flash_sector_map.sv
// Byte address to sector index for a map of N_SMALL equal small sectors,
// one mid sector, one big sector and N_HUGE equal huge sectors (R1, R3).
module flash_sector_map #(
    parameter int ADDR_W   = 24,
    parameter int N_SMALL  = 8,
    parameter int SMALL_KB = 16,
    parameter int MID_KB   = 128,
    parameter int BIG_KB   = 256,
    parameter int N_HUGE   = 3,
    parameter int HUGE_KB  = 512,
    localparam int N_SECT  = N_SMALL + 2 + N_HUGE,
    localparam int SECT_W  = $clog2(N_SECT)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SECT_W-1:0] sect,
    output logic              in_range
);

    function automatic logic [63:0] sect_bytes(int i);
        if (i < N_SMALL)       return 64'(SMALL_KB) * 64'd1024;
        else if (i == N_SMALL) return 64'(MID_KB) * 64'd1024;
        else if (i == N_SMALL + 1) return 64'(BIG_KB) * 64'd1024;
        else                   return 64'(HUGE_KB) * 64'd1024;
    endfunction

    function automatic logic [63:0] sect_base(int i);
        logic [63:0] sum = '0;
        for (int k = 0; k < i; k++) sum += sect_bytes(k);
        return sum;
    endfunction

    localparam logic [63:0] TOTAL_BYTES = sect_base(N_SECT);

    // Thermometer of "address at or above this sector's base"
    logic [N_SECT-1:0] above;

    for (genvar g = 0; g < N_SECT; g++) begin : g_base
        localparam logic [63:0] BASE = sect_base(g);
        assign above[g] = 64'(addr) >= BASE;
    end

    assign sect     = SECT_W'($countones(above) - 1);
    assign in_range = 64'(addr) < TOTAL_BYTES;

endmodule

// File: rtl/flash_key_seq.sv
// Two-word password sequencer with sticky error flag (R8, R9, R10).
module flash_key_seq #(
    parameter int              KEY_W = 64,
    parameter logic [KEY_W-1:0] KEY_A = 64'h0123_4567_89AB_CDEF,
    parameter logic [KEY_W-1:0] KEY_B = 64'hFEDC_BA98_7654_3210
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_vld,
    input  logic [KEY_W-1:0] word,
    input  logic             relock,
    output logic             word_ok,
    output logic             unlocked,
    output logic             pw_err
);

    typedef struct packed {
        logic second;
        logic unl;
        logic err;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d   = seq_q;
        word_ok = (word == (seq_q.second ? KEY_B : KEY_A));
        if (relock) begin
            seq_d.second = 1'b0;
            seq_d.unl    = 1'b0;
        end else if (word_vld) begin
            if (!word_ok) begin
                seq_d.second = 1'b0;
                seq_d.err    = 1'b1;
            end else if (seq_q.second) begin
                seq_d.second = 1'b0;
                seq_d.unl    = 1'b1;
            end else begin
                seq_d.second = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign unlocked = seq_q.unl;
    assign pw_err   = seq_q.err;

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int               ADDR_W     = 24,
    parameter int               DATA_W     = 64,
    parameter int               KEY_W      = 64,
    parameter int               PAGE_BYTES = 256,
    parameter int               N_SMALL    = 8,
    parameter int               SMALL_KB   = 16,
    parameter int               MID_KB     = 128,
    parameter int               BIG_KB     = 256,
    parameter int               N_HUGE     = 3,
    parameter int               HUGE_KB    = 512,
    parameter logic [KEY_W-1:0] KEY_A      = 64'h0123_4567_89AB_CDEF,
    parameter logic [KEY_W-1:0] KEY_B      = 64'hFEDC_BA98_7654_3210,
    localparam int              N_SECT     = N_SMALL + 2 + N_HUGE,
    localparam int              SECT_W     = $clog2(N_SECT),
    localparam int              PAGE_LSB   = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SECT-1:0] cfg_wp,
    input  logic [N_SECT-1:0] cfg_lock,
    input  logic              cfg_rdprot,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [KEY_W-1:0]  cmd_key,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [2:0]        rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_viol,
    output logic              pw_err,
    output logic              arr_req,
    output logic [2:0]        arr_op,
    output logic [SECT_W-1:0] arr_sector,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [DATA_W-1:0] arr_rdata
);

    typedef struct packed {
        logic [N_SECT-1:0] wp;
        logic [N_SECT-1:0] lock;
        logic              rdprot;
        logic              rv;
        logic              rg;
        err_e              re;
        logic [DATA_W-1:0] rd;
        logic              rviol;
    } guard_t;

    guard_t state_d, state_q;

    logic [SECT_W-1:0] sect;
    logic              in_rng;
    logic              word_ok;
    logic              unlocked;
    logic              key_vld;
    logic              relock;
    op_e               op;
    err_e              err;
    logic              rd_block;
    logic              sect_lock;
    logic              sect_wp;

    flash_sector_map #(
        .ADDR_W(ADDR_W), .N_SMALL(N_SMALL), .SMALL_KB(SMALL_KB),
        .MID_KB(MID_KB), .BIG_KB(BIG_KB), .N_HUGE(N_HUGE), .HUGE_KB(HUGE_KB)
    ) u_map (
        .addr     (cmd_addr),
        .sect     (sect),
        .in_range (in_rng)
    );

    flash_key_seq #(.KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (key_vld),
        .word     (cmd_key),
        .relock   (relock),
        .word_ok  (word_ok),
        .unlocked (unlocked),
        .pw_err   (pw_err)
    );

    assign op        = op_e'(cmd_op);
    assign key_vld   = cmd_valid && (op == OP_KEY);
    assign relock    = cmd_valid && (op == OP_RELOCK);
    assign rd_block  = state_q.rdprot && !unlocked;
    assign sect_lock = state_q.lock[sect];
    assign sect_wp   = state_q.wp[sect];

    // Decision: priority range, alignment, lock, read protection, write protection
    always_comb begin
        err = ERR_OK;
        unique case (op)
            OP_READ: begin
                if (!in_rng)        err = ERR_RANGE;
                else if (rd_block)  err = ERR_RPROT;
            end
            OP_PROG, OP_ERASE: begin
                if (!in_rng)                    err = ERR_RANGE;
                else if (op == OP_PROG && cmd_addr[PAGE_LSB-1:0] != '0)
                                                err = ERR_MISALIGN;
                else if (sect_lock)             err = ERR_LOCKED;
                else if (rd_block)              err = ERR_RPROT;
                else if (sect_wp && !unlocked)  err = ERR_WPROT;
            end
            OP_KEY:    if (!word_ok) err = ERR_BADKEY;
            OP_RELOCK: err = ERR_OK;
            OP_WPSET: begin
                if (!in_rng)         err = ERR_RANGE;
                else if (sect_lock)  err = ERR_LOCKED;
            end
            default: err = ERR_BADOP;
        endcase
    end

    always_comb begin
        state_d       = state_q;
        state_d.rv    = cmd_valid;
        state_d.rg    = cmd_valid && (err == ERR_OK);
        state_d.re    = cmd_valid ? err : ERR_OK;
        state_d.rviol = cmd_valid && (op == OP_READ) && (err == ERR_RPROT);
        state_d.rd    = (cmd_valid && op == OP_READ && err == ERR_OK)
                        ? arr_rdata : '0;
        if (cmd_valid && op == OP_WPSET && err == ERR_OK)
            state_d.wp[sect] = cmd_key[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= '0;
            state_q.wp     <= cfg_wp;
            state_q.lock   <= cfg_lock;
            state_q.rdprot <= cfg_rdprot;
        end else begin
            state_q <= state_d;
        end
    end

    assign cmd_ready  = 1'b1;
    assign arr_req    = cmd_valid && (err == ERR_OK) &&
                        (op == OP_READ || op == OP_PROG || op == OP_ERASE);
    assign arr_op     = cmd_op;
    assign arr_sector = sect;
    assign arr_addr   = cmd_addr;

    assign rsp_valid  = state_q.rv;
    assign rsp_grant  = state_q.rg;
    assign rsp_err    = state_q.re;
    assign rsp_rdata  = state_q.rd;
    assign rsp_viol   = state_q.rviol;

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk
    import flash_guard_pkg::*;
#(
    parameter int N_SECT   = 13,
    parameter int SECT_W   = 4,
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 64,
    parameter int PAGE_LSB = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              arr_req,
    input logic [2:0]        arr_op,
    input logic [SECT_W-1:0] arr_sector,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              rsp_valid,
    input logic              rsp_grant,
    input logic [2:0]        rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_viol,
    input logic              pw_err,
    input logic [N_SECT-1:0] lock_mask,
    input logic              rdprot,
    input logic              unlocked
);

    a_r12_grant_matches_err: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant == (rsp_err == ERR_OK)));

    a_r5_req_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> cmd_valid);

    a_r3_range_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err == ERR_RANGE) |-> !$past(arr_req));

    a_r4_prog_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && arr_op == OP_PROG) |-> (arr_addr[PAGE_LSB-1:0] == '0));

    a_r6_locked_never_written: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && arr_op != OP_READ) |-> !lock_mask[arr_sector]);

    a_r7_rdprot_blocks_array: assert property (@(posedge clk) disable iff (!rst_n)
        (rdprot && !unlocked) |-> !arr_req);

    a_r7_viol_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_viol |-> (rsp_rdata == '0 && !rsp_grant && rsp_err == ERR_RPROT));

    a_r9_pw_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pw_err |=> pw_err);

endmodule

bind flash_guard flash_guard_chk #(
    .N_SECT(N_SECT), .SECT_W(SECT_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .PAGE_LSB(PAGE_LSB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .arr_req    (arr_req),
    .arr_op     (arr_op),
    .arr_sector (arr_sector),
    .arr_addr   (arr_addr),
    .rsp_valid  (rsp_valid),
    .rsp_grant  (rsp_grant),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .rsp_viol   (rsp_viol),
    .pw_err     (pw_err),
    .lock_mask  (state_q.lock),
    .rdprot     (state_q.rdprot),
    .unlocked   (unlocked)
);

// File: tb/test_flash_guard.sv
module test_flash_guard;

    localparam logic [63:0] KA = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] KB = 64'hFEDC_BA98_7654_3210;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] cfg_wp = '0;
    logic [12:0] cfg_lock = '0;
    logic        cfg_rdprot = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [23:0] cmd_addr = '0;
    logic [63:0] cmd_key = '0;
    logic        rsp_valid, rsp_grant, rsp_viol, pw_err, arr_req;
    logic [2:0]  rsp_err, arr_op;
    logic [63:0] rsp_rdata, arr_rdata;
    logic [3:0]  arr_sector;
    logic [23:0] arr_addr;

    int n_checks = 0;
    int n_errors = 0;

    // 250 MHz: 4 time units per period
    always #2 clk = ~clk;

    // Array model: data is a tag plus the address
    assign arr_rdata = {40'hC0_FFEE_F1A5, arr_addr};

    flash_guard i_flash_guard (
        .clk(clk), .rst_n(rst_n), .cfg_wp(cfg_wp), .cfg_lock(cfg_lock),
        .cfg_rdprot(cfg_rdprot), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_key(cmd_key),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .rsp_viol(rsp_viol), .pw_err(pw_err),
        .arr_req(arr_req), .arr_op(arr_op), .arr_sector(arr_sector),
        .arr_addr(arr_addr), .arr_rdata(arr_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic issue(input logic [2:0] op, input logic [23:0] addr,
                         input logic [63:0] key, input logic [2:0] exp_err,
                         input int exp_sect, input string req);
        logic        exp_req;
        logic [63:0] exp_rd;
        exp_req = (exp_err == 3'd0) && (op <= 3'd2);
        exp_rd  = (op == 3'd0 && exp_err == 3'd0) ? {40'hC0_FFEE_F1A5, addr} : 64'd0;
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_key = key;
        #1;
        chk(arr_req == exp_req, req, "arr_req", 64'(arr_req), 64'(exp_req));
        if (exp_req)
            chk(arr_op == op && arr_addr == addr, req, "arr_op/addr",
                {37'd0, arr_op, arr_addr}, {37'd0, op, addr});
        if (exp_sect >= 0)
            chk(arr_sector == 4'(exp_sect), req, "arr_sector",
                64'(arr_sector), 64'(exp_sect));
        @(negedge clk);
        chk(rsp_valid == 1'b1, req, "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_err == exp_err, req, "rsp_err", 64'(rsp_err), 64'(exp_err));
        chk(rsp_grant == (exp_err == 3'd0), req, "rsp_grant",
            64'(rsp_grant), 64'(exp_err == 3'd0));
        chk(rsp_rdata == exp_rd, req, "rsp_rdata", rsp_rdata, exp_rd);
        chk(rsp_viol == (op == 3'd0 && exp_err == 3'd5), req, "rsp_viol",
            64'(rsp_viol), 64'(op == 3'd0 && exp_err == 3'd5));
    endtask

    task automatic idle();
        cmd_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset(input logic [12:0] wp, input logic [12:0] lk, input logic rp);
        @(negedge clk);
        cmd_valid = 1'b0; rst_n = 1'b0;
        cfg_wp = wp; cfg_lock = lk; cfg_rdprot = rp;
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R2", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        chk(pw_err == 1'b0, "R2", "pw_err in reset", 64'(pw_err), 64'd0);
        chk(cmd_ready == 1'b1, "R2", "cmd_ready", 64'(cmd_ready), 64'd1);
        rst_n = 1'b1;
        cfg_wp = '0; cfg_lock = '0; cfg_rdprot = 1'b0; // changes after release ignored
        @(negedge clk);
    endtask

    task automatic t_map();   // R1
        issue(3'd0, 24'h000000, 64'd0, 3'd0, 0,  "R1");
        issue(3'd0, 24'h003FFF, 64'd0, 3'd0, 0,  "R1");
        issue(3'd0, 24'h004000, 64'd0, 3'd0, 1,  "R1");
        issue(3'd0, 24'h01C000, 64'd0, 3'd0, 7,  "R1");
        issue(3'd0, 24'h01FFFF, 64'd0, 3'd0, 7,  "R1");
        issue(3'd0, 24'h020000, 64'd0, 3'd0, 8,  "R1");
        issue(3'd0, 24'h03FFFF, 64'd0, 3'd0, 8,  "R1");
        issue(3'd0, 24'h040000, 64'd0, 3'd0, 9,  "R1");
        issue(3'd0, 24'h080000, 64'd0, 3'd0, 10, "R1");
        issue(3'd0, 24'h100000, 64'd0, 3'd0, 11, "R1");
        issue(3'd0, 24'h180000, 64'd0, 3'd0, 12, "R1");
        issue(3'd0, 24'h1FFFFF, 64'd0, 3'd0, 12, "R1");
        idle();
    endtask

    task automatic t_range();   // R3
        issue(3'd0, 24'h200000, 64'd0, 3'd2, -1, "R3");
        issue(3'd2, 24'hFFFFFF, 64'd0, 3'd2, -1, "R3");
        issue(3'd1, 24'h200000, 64'd0, 3'd2, -1, "R3");
        idle();
    endtask

    task automatic t_align();   // R4
        issue(3'd1, 24'h004010, 64'd0, 3'd1, -1, "R4");
        issue(3'd1, 24'h0040FF, 64'd0, 3'd1, -1, "R4");
        issue(3'd1, 24'h004100, 64'd0, 3'd0, 1,  "R4");
        idle();
    endtask

    task automatic t_wprot();   // R5
        issue(3'd1, 24'h008000, 64'd0, 3'd3, 2, "R5");
        issue(3'd2, 24'h040000, 64'd0, 3'd3, 9, "R5");
        issue(3'd2, 24'h004000, 64'd0, 3'd0, 1, "R5");
        issue(3'd2, 24'h0C0000, 64'd0, 3'd0, 10, "R5");
        idle();
    endtask

    task automatic t_locked_badop();   // R6, R12
        issue(3'd2, 24'h180000, 64'd0, 3'd4, 12, "R6");
        issue(3'd1, 24'h1FFF00, 64'd0, 3'd4, 12, "R6");
        issue(3'd5, 24'h180000, 64'd0, 3'd4, 12, "R6");
        issue(3'd6, 24'h000000, 64'd0, 3'd7, -1, "R12");
        issue(3'd7, 24'h000000, 64'd0, 3'd7, -1, "R12");
        idle();
    endtask

    task automatic t_wpset();   // R11
        issue(3'd5, 24'h004000, 64'd1, 3'd0, 1, "R11");
        issue(3'd1, 24'h004000, 64'd0, 3'd3, 1, "R11");
        issue(3'd5, 24'h004000, 64'd0, 3'd0, 1, "R11");
        issue(3'd1, 24'h004000, 64'd0, 3'd0, 1, "R11");
        idle();
    endtask

    task automatic t_password();   // R8, R9, R10
        issue(3'd3, 24'h0, 64'h1234, 3'd6, -1, "R9");
        chk(pw_err == 1'b1, "R9", "pw_err set", 64'(pw_err), 64'd1);
        issue(3'd3, 24'h0, KA, 3'd0, -1, "R8");
        issue(3'd3, 24'h0, KB, 3'd0, -1, "R8");
        issue(3'd1, 24'h008000, 64'd0, 3'd0, 2, "R8");   // back to back after unlock
        issue(3'd2, 24'h040000, 64'd0, 3'd0, 9, "R8");
        issue(3'd2, 24'h180000, 64'd0, 3'd4, 12, "R6");  // lock survives unlock
        issue(3'd4, 24'h0, 64'd0, 3'd0, -1, "R10");
        issue(3'd1, 24'h008000, 64'd0, 3'd3, 2, "R10");  // back to back after relock
        issue(3'd3, 24'h0, KA, 3'd0, -1, "R9");
        issue(3'd3, 24'h0, 64'd0, 3'd6, -1, "R9");
        issue(3'd3, 24'h0, KB, 3'd6, -1, "R9");          // sequence restarted
        issue(3'd1, 24'h008000, 64'd0, 3'd3, 2, "R9");
        idle();
        chk(pw_err == 1'b1, "R9", "pw_err sticky", 64'(pw_err), 64'd1);
        issue(3'd3, 24'h0, KA, 3'd0, -1, "R10");
        issue(3'd4, 24'h0, 64'd0, 3'd0, -1, "R10");
        issue(3'd3, 24'h0, KB, 3'd6, -1, "R10");         // relock restarted sequence
        idle();
    endtask

    task automatic t_rdprot();   // R7, R8
        issue(3'd0, 24'h000100, 64'd0, 3'd5, -1, "R7");
        issue(3'd1, 24'h000000, 64'd0, 3'd5, -1, "R7");
        issue(3'd2, 24'h004000, 64'd0, 3'd5, -1, "R7");
        issue(3'd2, 24'h180000, 64'd0, 3'd4, -1, "R7");
        issue(3'd3, 24'h0, KA, 3'd0, -1, "R8");
        issue(3'd3, 24'h0, KB, 3'd0, -1, "R8");
        issue(3'd0, 24'h000100, 64'd0, 3'd0, 0, "R8");
        issue(3'd1, 24'h000000, 64'd0, 3'd0, 0, "R8");
        issue(3'd4, 24'h0, 64'd0, 3'd0, -1, "R7");
        issue(3'd0, 24'h000100, 64'd0, 3'd5, -1, "R7");
        idle();
    endtask

    initial begin
        t_reset(13'h0204, 13'h1000, 1'b0);
        t_map();
        t_range();
        t_align();
        t_wprot();
        t_locked_badop();
        t_wpset();
        t_password();
        t_reset(13'h0000, 13'h1000, 1'b1);
        chk(pw_err == 1'b0, "R2", "pw_err cleared by reset", 64'(pw_err), 64'd0);
        t_rdprot();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule